// File: doc/BRIEF.md
# Sliding Goertzel Single-Bin DFT

This block tracks one frequency bin of a real sample stream over a window of the most recent samples. It updates the bin once per input sample. The recursive part works only in real arithmetic, so the per-sample work is one real multiply in the loop and two real multiplies at the output. A phase detector or a harmonic analyser downstream reads the bin as an in-phase and a quadrature part.

Each accepted sample passes through three stages:

- **Comb stage.** It subtracts the sample that arrived one window earlier.
- **Resonator.** A two-delay resonator with a single real coefficient accumulates the comb result.
- **Output mix.** A registered feed-forward stage turns the resonator's current and previous state into the complex bin value.

The zeros of the comb cancel the resonator's pole pair, so only the selected bin gets through. All other bin frequencies of the window land on zeros on the unit circle.

The default build uses a window of 20 samples and bin 2. The three coefficients are Q2.14 values: twice the cosine, the cosine, and the sine of 2π·bin/window. They are computed at elaboration. Resonator state is 32-bit signed and wraps on overflow.

Top module: `sgdft_bin`

## Requirements
- R1: While `rst_n` is low, `bin_i`, `bin_q` and `bin_vld` are 0, the window history is cleared, and both resonator states are 0.
- R2: On each cycle with `smp_stb` high, the comb value is `smp_in` minus the sample accepted WIN_LEN strobes earlier. Positions in the window not yet filled since reset count as 0.
- R3: On each strobe, the resonator computes the new state as comb + ((C2·v1) >>> 14) − v2. Here v1 and v2 are the two previous states, `>>>` is an arithmetic (floor) shift, and the sum wraps to 32 bits.
- R4: One cycle after a strobe, `bin_i` becomes v0 − ((C·v1) >>> 14), wrapped to 32 bits. Here v0 is the state just computed and v1 is the state before it.
- R5: One cycle after a strobe, `bin_q` becomes (S·v1) >>> 14, with v1 the state before the newest one. Its sign therefore follows v1.
- R6: `bin_i`, `bin_q` and `bin_vld` change only on the clock edge that directly follows a strobe edge. On the strobe edge itself they still show the previous result.
- R7: `bin_vld` is high for one cycle after each strobe from the WIN_LEN-th strobe since reset onward. It stays low for the earlier strobes and on every cycle not following a strobe.
- R8: Cycles with `smp_stb` low leave the window history, the resonator and the outputs untouched, whatever value `smp_in` carries.
- R9: For WIN_LEN=20 and BIN_IDX=2 the coefficients are C2 = 26510, C = 13255 and S = 9630, which are the Q2.14 roundings of 2cos(π/5), cos(π/5) and sin(π/5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe, one accepted sample per high cycle |
| smp_in | input | SAMPLE_W | Signed input sample |
| bin_i | output | VAL_W | Signed in-phase part of the bin |
| bin_q | output | VAL_W | Signed quadrature part of the bin |
| bin_vld | output | 1 | Pulse marking a result taken over a full window |

## Verification
The bench builds the block with its defaults: a 20-sample window, bin 2, 16-bit samples and 32-bit state. With these values an impulse exposes the three Q2.14 constants directly in the first two results. A tone on bin 2 and a mix of other bins of the same window show the pass and reject behaviour, and the effect of quantised pole-zero cancellation is visible bit for bit. Alternating full-scale samples drive the 17-bit comb result and the resonator toward wrap. The 20-strobe fill gives a short, fully observable boundary for the valid flag.

// File: rtl/sgdft_pkg.sv
package sgdft_pkg;

   localparam real PI_R = 3.14159265358979323846;

   // cosine by series expansion after folding the angle into [-pi, pi]
   function automatic real cos_series(input real ang);
      real a;
      real term;
      real acc;
      a = ang;
      while (a > PI_R)  a = a - 2.0 * PI_R;
      while (a < -PI_R) a = a + 2.0 * PI_R;
      term = 1.0;
      acc  = 1.0;
      for (int i = 1; i < 30; i++) begin
         term = -term * a * a / ((2.0 * i - 1.0) * (2.0 * i));
         acc  = acc + term;
      end
      return acc;
   endfunction

   function automatic real sin_series(input real ang);
      return cos_series(ang - PI_R / 2.0);
   endfunction

   // round a real value to a signed fixed-point integer with frac fractional bits
   function automatic int to_fixed(input real val, input int frac);
      real scaled;
      scaled = val * (2.0 ** frac);
      if (scaled >= 0.0) return $rtoi(scaled + 0.5);
      else               return -$rtoi(-scaled + 0.5);
   endfunction

   function automatic real bin_angle(input int bin, input int win);
      return 2.0 * PI_R * bin / win;
   endfunction

endpackage

// File: rtl/sgdft_comb.sv
module sgdft_comb #(
   parameter int WIN   = 20,
   parameter int DW    = 16,
   parameter int VW    = 32,
   localparam int CNTW = $clog2(WIN + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stb,
   input  logic signed [DW-1:0] x,
   output logic signed [VW-1:0] comb,
   output logic                 full_now
);

   logic signed [DW-1:0] tap [WIN];
   logic [CNTW-1:0]      fill;
   logic signed [DW:0]   diff;

   // window history: tap[WIN-1] holds the sample from WIN strobes back
   generate
      for (genvar g = 0; g < WIN; g++) begin : g_tap
         if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   tap[g] <= '0;
               else if (stb) tap[g] <= x;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   tap[g] <= '0;
               else if (stb) tap[g] <= tap[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             fill <= '0;
      else if (stb && fill != CNTW'(WIN))     fill <= fill + 1'b1;
   end

   assign diff     = {x[DW-1], x} - {tap[WIN-1][DW-1], tap[WIN-1]};
   assign comb     = VW'(diff);
   assign full_now = (fill >= CNTW'(WIN - 1));

endmodule

// File: rtl/sgdft_reso.sv
module sgdft_reso #(
   parameter int VW   = 32,
   parameter int CW   = 16,
   parameter int FRAC = 14,
   parameter int C2   = 26510,
   localparam int PW  = VW + CW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stb,
   input  logic signed [VW-1:0] comb,
   output logic signed [VW-1:0] v_cur,
   output logic signed [VW-1:0] v_prev
);

   localparam logic signed [CW-1:0] C2_S = CW'(C2);

   logic signed [PW-1:0] fb_prod;
   logic signed [VW-1:0] fb_term;
   logic signed [VW-1:0] v_next;

   assign fb_prod = v_cur * C2_S;
   assign fb_term = VW'(fb_prod >>> FRAC);
   assign v_next  = comb + fb_term - v_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_cur  <= '0;
         v_prev <= '0;
      end else if (stb) begin
         v_cur  <= v_next;
         v_prev <= v_cur;
      end
   end

endmodule

// File: rtl/sgdft_outmix.sv
module sgdft_outmix #(
   parameter int VW   = 32,
   parameter int CW   = 16,
   parameter int FRAC = 14,
   parameter int CC   = 13255,
   parameter int SS   = 9630,
   localparam int PW  = VW + CW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic                 go_full,
   input  logic signed [VW-1:0] v_cur,
   input  logic signed [VW-1:0] v_prev,
   output logic signed [VW-1:0] re_o,
   output logic signed [VW-1:0] im_o,
   output logic                 vld_o
);

   localparam logic signed [CW-1:0] CC_S = CW'(CC);
   localparam logic signed [CW-1:0] SS_S = CW'(SS);

   logic signed [PW-1:0] c_prod;
   logic signed [PW-1:0] s_prod;

   assign c_prod = v_prev * CC_S;
   assign s_prod = v_prev * SS_S;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         re_o  <= '0;
         im_o  <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= go & go_full;
         if (go) begin
            re_o <= v_cur - VW'(c_prod >>> FRAC);
            im_o <= VW'(s_prod >>> FRAC);
         end
      end
   end

endmodule

// File: rtl/sgdft_bin.sv
module sgdft_bin #(
   parameter int SAMPLE_W  = 16,
   parameter int VAL_W     = 32,
   parameter int COEF_W    = 16,
   parameter int COEF_FRAC = 14,
   parameter int WIN_LEN   = 20,
   parameter int BIN_IDX   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_stb,
   input  logic [SAMPLE_W-1:0] smp_in,
   output logic [VAL_W-1:0]    bin_i,
   output logic [VAL_W-1:0]    bin_q,
   output logic                bin_vld
);

   localparam real ANG   = sgdft_pkg::bin_angle(BIN_IDX, WIN_LEN);
   localparam int  C2_Q  = sgdft_pkg::to_fixed(2.0 * sgdft_pkg::cos_series(ANG), COEF_FRAC);
   localparam int  C_Q   = sgdft_pkg::to_fixed(sgdft_pkg::cos_series(ANG), COEF_FRAC);
   localparam int  S_Q   = sgdft_pkg::to_fixed(sgdft_pkg::sin_series(ANG), COEF_FRAC);
   localparam int  CMAX  = 2 ** (COEF_W - 1);

   generate
      if (WIN_LEN < 2) begin : g_bad_win
         $error("window length must be at least 2");
      end
      if (BIN_IDX < 1 || BIN_IDX >= WIN_LEN) begin : g_bad_bin
         $error("bin index must lie in 1 .. window length - 1");
      end
      if (C2_Q >= CMAX || C2_Q < -CMAX) begin : g_bad_coef
         $error("coefficient width too small for the feedback coefficient");
      end
      if (VAL_W < SAMPLE_W + 1 + COEF_W - COEF_FRAC) begin : g_bad_val
         $error("state width too small for the comb result");
      end
   endgenerate

   logic signed [VAL_W-1:0] comb_v;
   logic                    full_now;
   logic signed [VAL_W-1:0] v_cur;
   logic signed [VAL_W-1:0] v_prev;
   logic                    stb_d;
   logic                    full_d;
   logic signed [VAL_W-1:0] re_w;
   logic signed [VAL_W-1:0] im_w;

   sgdft_comb #(
      .WIN (WIN_LEN),
      .DW  (SAMPLE_W),
      .VW  (VAL_W)
   ) u_comb (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (smp_stb),
      .x        ($signed(smp_in)),
      .comb     (comb_v),
      .full_now (full_now)
   );

   sgdft_reso #(
      .VW   (VAL_W),
      .CW   (COEF_W),
      .FRAC (COEF_FRAC),
      .C2   (C2_Q)
   ) u_reso (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (smp_stb),
      .comb   (comb_v),
      .v_cur  (v_cur),
      .v_prev (v_prev)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_d  <= 1'b0;
         full_d <= 1'b0;
      end else begin
         stb_d  <= smp_stb;
         full_d <= smp_stb & full_now;
      end
   end

   sgdft_outmix #(
      .VW   (VAL_W),
      .CW   (COEF_W),
      .FRAC (COEF_FRAC),
      .CC   (C_Q),
      .SS   (S_Q)
   ) u_mix (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (stb_d),
      .go_full (full_d),
      .v_cur   (v_cur),
      .v_prev  (v_prev),
      .re_o    (re_w),
      .im_o    (im_w),
      .vld_o   (bin_vld)
   );

   assign bin_i = re_w;
   assign bin_q = im_w;

endmodule

// File: rtl/sgdft_bin_chk.sv
module sgdft_bin_chk #(
   parameter int VAL_W   = 32,
   parameter int WIN_LEN = 20,
   localparam int CNTW   = $clog2(WIN_LEN + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_stb,
   input logic [VAL_W-1:0] bin_i,
   input logic [VAL_W-1:0] bin_q,
   input logic             bin_vld,
   input logic [VAL_W-1:0] v_prev
);

   logic [CNTW-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 seen <= '0;
      else if (smp_stb && seen != CNTW'(WIN_LEN)) seen <= seen + 1'b1;
   end

   // R6
   vld_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bin_vld |-> $past(smp_stb, 2));

   // R6
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_stb, 2) |-> ($stable(bin_i) && $stable(bin_q)));

   // R7
   vld_fill_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bin_vld |-> ($past(seen, 2) >= CNTW'(WIN_LEN - 1)));

   // R7
   vld_fill_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(smp_stb, 2) && $past(seen, 2) >= CNTW'(WIN_LEN - 1)) |-> bin_vld);

   // R5
   q_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(smp_stb) |=> (bin_q[VAL_W-1] == $past(v_prev[VAL_W-1])));

endmodule

bind sgdft_bin sgdft_bin_chk #(
   .VAL_W   (VAL_W),
   .WIN_LEN (WIN_LEN)
) u_sgdft_bin_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .smp_stb (smp_stb),
   .bin_i   (bin_i),
   .bin_q   (bin_q),
   .bin_vld (bin_vld),
   .v_prev  (v_prev)
);

// File: tb/sgdft_bin_bench.sv
module sgdft_bin_bench;

   localparam int WIN   = 20;
   localparam int FR    = 14;
   localparam longint KC2 = 26510;
   localparam longint KC  = 13255;
   localparam longint KS  = 9630;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_stb = 1'b0;
   logic [15:0] smp_in = '0;
   logic [31:0] bin_i;
   logic [31:0] bin_q;
   logic        bin_vld;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // model state
   int     hist [WIN];
   int     hidx;
   int     scnt;
   longint mv;
   longint mv1;
   int     exp_i;
   int     exp_q;
   bit     exp_v;

   always #10 clk = ~clk;

   sgdft_bin u_sgdft_bin (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_stb (smp_stb),
      .smp_in  (smp_in),
      .bin_i   (bin_i),
      .bin_q   (bin_q),
      .bin_vld (bin_vld)
   );

   task automatic chk(input string req, input string what, input longint act, input longint expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic longint shr(input longint p);
      return p >>> FR;
   endfunction

   function automatic longint w32(input longint v);
      int t;
      t = int'(v);
      return longint'(t);
   endfunction

   function automatic int as_int(input logic [31:0] v);
      return $signed(v);
   endfunction

   task automatic model_clear();
      for (int i = 0; i < WIN; i++) hist[i] = 0;
      hidx = 0; scnt = 0; mv = 0; mv1 = 0;
      exp_i = 0; exp_q = 0; exp_v = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; smp_stb = 1'b0; smp_in = 16'h1234;
      model_clear();
      repeat (3) @(negedge clk);
      // R1
      chk("R1", "bin_i in reset", as_int(bin_i), 0);
      chk("R1", "bin_q in reset", as_int(bin_q), 0);
      chk("R1", "bin_vld in reset", bin_vld, 0);
      rst_n = 1'b1;
   endtask

   // one sample: strobe for one cycle, check hold on strobe edge, then new result
   task automatic send(input int x);
      int     old_i, old_q, delayed;
      longint comb, nv;
      old_i = exp_i; old_q = exp_q;
      @(negedge clk);
      smp_in = x[15:0]; smp_stb = 1'b1;
      // R2 comb with zero history before fill
      delayed = hist[hidx];
      hist[hidx] = x;
      hidx = (hidx + 1) % WIN;
      comb = longint'(x) - longint'(delayed);
      // R3 resonator
      nv = w32(comb + shr(KC2 * mv) - mv1);
      // R4, R5 output mix
      exp_i = int'(w32(nv - shr(KC * mv)));
      exp_q = int'(w32(shr(KS * mv)));
      mv1 = mv; mv = nv;
      scnt++;
      exp_v = (scnt >= WIN);
      @(negedge clk);
      smp_stb = 1'b0;
      // R6 strobe edge passed, outputs still old
      chk("R6", "bin_i before update", as_int(bin_i), old_i);
      chk("R6", "bin_q before update", as_int(bin_q), old_q);
      chk("R6", "bin_vld before update", bin_vld, 0);
      @(negedge clk);
      chk("R4", "bin_i", as_int(bin_i), exp_i);
      chk("R5", "bin_q", as_int(bin_q), exp_q);
      chk("R7", "bin_vld", bin_vld, exp_v);
   endtask

   task automatic test_impulse();
      do_reset();
      send(1000);
      // R9 first result exposes nothing of the coefficients, second does
      chk("R9", "impulse i0", as_int(bin_i), 1000);
      chk("R9", "impulse q0", as_int(bin_q), 0);
      send(0);
      chk("R9", "impulse i1 (C2,C)", as_int(bin_i), 1618 - 809);
      chk("R9", "impulse q1 (S)", as_int(bin_q), 587);
      for (int n = 2; n < 45; n++) send(0);
   endtask

   task automatic test_tone();
      do_reset();
      for (int n = 0; n < 60; n++)
         send($rtoi(12000.0 * $cos(2.0 * 3.14159265358979 * 2.0 * n / WIN)));
   endtask

   task automatic test_mix();
      real a;
      do_reset();
      for (int n = 0; n < 50; n++) begin
         a = 2.0 * 3.14159265358979 * n / WIN;
         send($rtoi(9000.0 * $sin(2.0 * a) + 2000.0 * $cos(5.0 * a)
                    + 1500.0 * $sin(7.0 * a) + 800.0 * $cos(3.0 * a) + 300.0));
      end
   endtask

   task automatic test_idle();
      int hold_i, hold_q;
      do_reset();
      for (int n = 0; n < 25; n++) send((n * 733) % 4001 - 2000);
      hold_i = as_int(bin_i); hold_q = as_int(bin_q);
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         smp_in = 16'(c * 5119 + 77);
         smp_stb = 1'b0;
      end
      @(negedge clk);
      // R8 outputs untouched
      chk("R8", "bin_i idle", as_int(bin_i), hold_i);
      chk("R8", "bin_q idle", as_int(bin_q), hold_q);
      chk("R8", "bin_vld idle", bin_vld, 0);
      // R8 state untouched: later samples still match the model
      for (int n = 0; n < 20; n++) send(n * 97 - 900);
   endtask

   task automatic test_extremes();
      do_reset();
      for (int n = 0; n < 70; n++) send((n % 2 == 0) ? 32767 : -32768);
      for (int n = 0; n < 30; n++) send(((n / 5) % 2 == 0) ? -32768 : 32767);
   endtask

   initial begin
      model_clear();
      test_impulse();
      test_tone();
      test_mix();
      test_idle();
      test_extremes();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule